// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in, producing a sum of the same width and a carry-out. The operands are split into four-bit groups. Within a group, each bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). Every carry inside the group comes straight from a flat sum-of-products over those terms and the group's carry-in, so no carry ripples from bit to bit inside a group.

Each group also reports its own generate and propagate. The next group's carry-in is formed from these two terms and the current group's carry-in, so carries pass from one group to the next. Because propagate is the inclusive OR of the operand bits, each sum bit is formed as carry XOR propagate XOR generate.

The adder logic is combinational. Its results are captured in output registers that have a synchronous active-high reset, so every output appears one clock after its operands are sampled.

Top module: `cla_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum`, `cout`, `grp_gen` and `grp_prop` all become zero after that edge.
- R2: After a rising edge with `rst` low, the value {`cout`,`sum`} equals `a + b + cin` as sampled at that edge, computed as an unsigned WIDTH+1-bit result.
- R3: All-ones plus one with `cin` = 0, and all-ones plus zero with `cin` = 1, both give `sum` = 0 and `cout` = 1.
- R4: Zero plus zero gives `sum` equal to `cin` and `cout` = 0.
- R5: Group k covers operand bits 4k to 4k+3. Bit k of `grp_gen` is 1 exactly when the sum of the two operand slices of that group, with no carry-in, is 16 or more.
- R6: Bit k of `grp_prop` is 1 exactly when every bit position in group k has at least one operand bit set.
- R7: A carry produced in one group reaches the next group. For example, 0x0F + 0x01 gives 0x10, and alternating patterns such as 0x55 + 0xAB carry across every group boundary.
- R8: WIDTH must be a multiple of 4, the default is 16, and there are WIDTH/4 group outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the lowest bit |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the top bit |
| grp_gen | output | WIDTH/4 | Registered generate, one bit per group |
| grp_prop | output | WIDTH/4 | Registered propagate, one bit per group |

## Verification
The assertions assume that `a`, `b` and `cin` hold stable, known values around each rising edge. They also assume that the edge just before a check was a non-reset edge, because each result is compared with operands taken through `$past` one cycle back. The bench meets these conditions by changing inputs only on the falling edge and leaving reset low for the whole data phase. It sweeps every operand pair of an 8-bit instance, alternating `cin` with each pair. A second instance at the default width receives the listed corner operands and pseudo-random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int GRP_BITS = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } bit_pg_t;
endpackage

// File: rtl/cla_pg_bit.sv
module cla_pg_bit
  import cla_pkg::*;
(
  input  logic    x,
  input  logic    y,
  output bit_pg_t pg
);
  assign pg.gen  = x & y;
  assign pg.prop = x | y;
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
(
  input  bit_pg_t [GRP_BITS-1:0] pg,
  input  logic                   c_in,
  output logic    [GRP_BITS-1:0] s,
  output logic                   g_grp,
  output logic                   p_grp
);
  logic [GRP_BITS-1:0] g, p, c;

  always_comb begin
    for (int i = 0; i < GRP_BITS; i++) begin
      g[i] = pg[i].gen;
      p[i] = pg[i].prop;
    end
  end

  // Flat two-level carries: none uses another internal carry
  assign c[0] = c_in;
  assign c[1] = g[0] | (p[0] & c_in);
  assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_in);
  assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
              | (p[2] & p[1] & p[0] & c_in);

  assign g_grp = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
               | (p[3] & p[2] & p[1] & g[0]);
  assign p_grp = &p;

  // With inclusive-OR propagate, P ^ G restores the half-sum
  assign s = c ^ p ^ g;
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WIDTH-1:0]           a,
  input  logic [WIDTH-1:0]           b,
  input  logic                       cin,
  output logic [WIDTH-1:0]           sum,
  output logic                       cout,
  output logic [WIDTH/GRP_BITS-1:0]  grp_gen,
  output logic [WIDTH/GRP_BITS-1:0]  grp_prop
);
  localparam int NGRP = WIDTH / GRP_BITS;

  if (WIDTH % GRP_BITS != 0 || WIDTH < GRP_BITS) begin : g_bad_width
    $error("cla_adder: WIDTH must be a positive multiple of 4");
  end

  bit_pg_t [WIDTH-1:0] pg;
  logic    [WIDTH-1:0] s_c;
  logic    [NGRP:0]    gc;
  logic    [NGRP-1:0]  gg_c, gp_c;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    cla_pg_bit u_pg (.x(a[i]), .y(b[i]), .pg(pg[i]));
  end

  assign gc[0] = cin;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    cla_group u_grp (
      .pg   (pg[k*GRP_BITS +: GRP_BITS]),
      .c_in (gc[k]),
      .s    (s_c[k*GRP_BITS +: GRP_BITS]),
      .g_grp(gg_c[k]),
      .p_grp(gp_c[k])
    );
    assign gc[k+1] = gg_c[k] | (gp_c[k] & gc[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum      <= '0;
      cout     <= 1'b0;
      grp_gen  <= '0;
      grp_prop <= '0;
    end else begin
      sum      <= s_c;
      cout     <= gc[NGRP];
      grp_gen  <= gg_c;
      grp_prop <= gp_c;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (sum == '0 && cout == 1'b0 && grp_gen == '0 && grp_prop == '0));

  assert_sum_matches_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)}
                               + {{WIDTH{1'b0}}, $past(cin)})));

  for (genvar k = 0; k < NGRP; k++) begin : g_chk
    assert_group_gen_R5: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (grp_gen[k] == (({1'b0, $past(a[k*GRP_BITS +: GRP_BITS])}
                               + {1'b0, $past(b[k*GRP_BITS +: GRP_BITS])}) >= 5'd16)));

    // R6: propagate without generate means the slices are complementary
    assert_group_prop_R6: assert property (@(posedge clk) disable iff (rst)
      (!rst ##1 (grp_prop[k] && !grp_gen[k])) |->
        (($past(a[k*GRP_BITS +: GRP_BITS]) + $past(b[k*GRP_BITS +: GRP_BITS])) == 4'hF));
  end
endmodule

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W_S = 8;
  localparam int W_L = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W_S-1:0] a_s = '0, b_s = '0;
  logic [W_L-1:0] a_l = '0, b_l = '0;
  logic cin_s = 1'b0, cin_l = 1'b0;
  logic [W_S-1:0] sum_s;
  logic [W_L-1:0] sum_l;
  logic cout_s, cout_l;
  logic [W_S/4-1:0] gg_s, gp_s;
  logic [W_L/4-1:0] gg_l, gp_l;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cla_adder #(.WIDTH(W_S)) u_dut (
    .clk(clk), .rst(rst), .a(a_s), .b(b_s), .cin(cin_s),
    .sum(sum_s), .cout(cout_s), .grp_gen(gg_s), .grp_prop(gp_s));

  cla_adder u_dut_wide (
    .clk(clk), .rst(rst), .a(a_l), .b(b_l), .cin(cin_l),
    .sum(sum_l), .cout(cout_l), .grp_gen(gg_l), .grp_prop(gp_l));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W_L/4-1:0] exp_gg(input logic [W_L-1:0] x, input logic [W_L-1:0] y, input int n);
    logic [W_L/4-1:0] r = '0;
    for (int k = 0; k < n; k++)
      r[k] = ({1'b0, x[k*4 +: 4]} + {1'b0, y[k*4 +: 4]}) >= 5'd16;
    return r;
  endfunction

  function automatic logic [W_L/4-1:0] exp_gp(input logic [W_L-1:0] x, input logic [W_L-1:0] y, input int n);
    logic [W_L/4-1:0] r = '0;
    for (int k = 0; k < n; k++)
      r[k] = &(x[k*4 +: 4] | y[k*4 +: 4]);
    return r;
  endfunction

  // drive on the falling edge, result registered at the next rising edge
  task automatic run_wide(input string req, input logic [W_L-1:0] x, input logic [W_L-1:0] y, input logic c);
    logic [W_L:0] e;
    a_l = x; b_l = y; cin_l = c;
    @(posedge clk); @(negedge clk);
    e = {1'b0, x} + {1'b0, y} + {{W_L{1'b0}}, c};
    chk(req, {cout_l, sum_l}, e);
    chk("R5", gg_l, exp_gg(x, y, W_L/4));
    chk("R6", gp_l, exp_gp(x, y, W_L/4));
  endtask

  initial begin
    @(negedge clk);
    a_s = '1; b_s = '1; cin_s = 1'b1; a_l = '1; b_l = '1; cin_l = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", {cout_s, sum_s, gg_s, gp_s}, '0);
    chk("R1", {cout_l, sum_l, gg_l, gp_l}, '0);
    chk("R8", $bits(gg_l), W_L/4);
    rst = 1'b0;

    run_wide("R3", 16'hFFFF, 16'h0001, 1'b0);
    run_wide("R3", 16'hFFFF, 16'h0000, 1'b1);
    run_wide("R4", 16'h0000, 16'h0000, 1'b0);
    run_wide("R4", 16'h0000, 16'h0000, 1'b1);
    run_wide("R7", 16'h000F, 16'h0001, 1'b0);
    run_wide("R7", 16'h5555, 16'hAAAB, 1'b0);
    run_wide("R7", 16'hAAAA, 16'h5555, 1'b1);
    run_wide("R7", 16'h5555, 16'h5555, 1'b0);
    run_wide("R7", 16'hAAAA, 16'hAAAA, 1'b1);
    run_wide("R2", 16'hFFFF, 16'hFFFF, 1'b1);
    for (int i = 0; i < 2000; i++)
      run_wide("R2", 16'($urandom), 16'($urandom), 1'($urandom));

    // exhaustive sweep of the narrow instance
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        logic [W_S:0] e;
        a_s = 8'(x); b_s = 8'(y); cin_s = 1'((x + y) & 1);
        @(posedge clk); @(negedge clk);
        e = 9'(x + y + ((x + y) & 1));
        chk("R2", {cout_s, sum_s}, e);
        chk("R5", gg_s, 2'(exp_gg(16'(x), 16'(y), 2)));
        chk("R6", gp_s, 2'(exp_gp(16'(x), 16'(y), 2)));
      end
    end

    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", {cout_l, sum_l, gg_l, gp_l}, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule